// File: doc/BRIEF.md
# Fuse-Programmable AND-NOR Logic Array

This block is a reconfigurable two-level logic array. Eleven input signals are offered to every product term in both true and inverted form. A fuse bit at each crossing decides whether that literal takes part in the term's AND. Each of the three outputs has its own fixed group of four product terms and is driven low when any of them is true, so the outputs form an active-low sum of products. To get an active-high function, the user programs its complement.

A configuration port holds the fuse map. The map has twelve rows, one for each product term, and each row is 22 bits wide. A single command erases the whole map back to "all intact". A row write replaces one addressed term's 22 fuses. The row selected on the address lines is always visible on the read-back bus. The data path is purely combinational from the inputs and the stored map. A stored change becomes visible on the outputs once the clock edge that accepts it has passed.

Top module: `fuse_nor_array`

## Requirements
- R1: After reset, every fuse is intact (stored 0), every output is 1 and every row reads back as 0.
- R2: Within a row, bit 2*i is the true literal of input i and bit 2*i+1 is its inverted literal. A stored 1 means blown and a stored 0 means intact.
- R3: A product term is the AND of its intact literals only. A row with every fuse blown is constantly 1 and pulls its output low whatever the inputs are.
- R4: Output o is 0 exactly when at least one of the four terms in rows o*4 to o*4+3 is 1. Otherwise it is 1.
- R5: A term that keeps both literals of any input intact is 0 and has no effect on its output. An erased array therefore drives all outputs to 1.
- R6: A row write with cfg_wr high stores cfg_wdata into row cfg_out*4+cfg_term at the clock edge. Before that edge the outputs still follow the old map. After the edge both the outputs and the read-back follow the new map.
- R7: A clock edge with cfg_erase high returns all twelve rows to 0 in that single cycle.
- R8: cfg_busy is high while cfg_erase is high. A write presented in the same cycle is dropped, and the addressed row reads 0 afterwards.
- R9: A write whose output index is 3 or higher changes no row, and a read at such an index returns 0.
- R10: Writing a row belonging to one output never changes the other outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset, erases the map |
| in_data | input | 11 | Logic inputs |
| out_n | output | 3 | Active-low array outputs |
| cfg_erase | input | 1 | Erase the whole map at this edge |
| cfg_wr | input | 1 | Write one row at this edge |
| cfg_out | input | 2 | Output index of the addressed row |
| cfg_term | input | 2 | Term index within that output |
| cfg_wdata | input | 22 | Fuse bits for the write, 1 = blown |
| cfg_rdata | output | 22 | Fuse bits of the addressed row |
| cfg_busy | output | 1 | Erase in progress, writes rejected |

## Verification
Erase and row write can fall on the same edge. When they do, the erase must win and the write must leave no trace. The bench provokes this directly by raising cfg_erase and cfg_wr together with an all-blown row, and it also mixes erase pulses into the random write stream. It judges the outcome by checking that cfg_busy was high in that cycle, that the addressed row reads 0 afterwards, and that every output returned to 1.

// File: rtl/fuse_nor_array.sv
module fuse_nor_array #(
  parameter int N_IN   = 11,
  parameter int N_OUT  = 3,
  parameter int N_TERM = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [N_IN-1:0]                   in_data,
  output logic [N_OUT-1:0]                  out_n,
  input  logic                              cfg_erase,
  input  logic                              cfg_wr,
  input  logic [(N_OUT>1?$clog2(N_OUT):1)-1:0]   cfg_out,
  input  logic [(N_TERM>1?$clog2(N_TERM):1)-1:0] cfg_term,
  input  logic [2*N_IN-1:0]                 cfg_wdata,
  output logic [2*N_IN-1:0]                 cfg_rdata,
  output logic                              cfg_busy
);
  localparam int LW   = 2 * N_IN;
  localparam int ROWS = N_OUT * N_TERM;
  localparam int OW   = N_OUT > 1 ? $clog2(N_OUT) : 1;
  localparam int TW   = N_TERM > 1 ? $clog2(N_TERM) : 1;
  localparam int RW   = $clog2(N_OUT * (1 << TW));

  logic [LW-1:0]   fuse_q [ROWS];
  logic [LW-1:0]   lit;
  logic [ROWS-1:0] term;
  logic [RW-1:0]   row_idx;
  logic            addr_ok;

  assign addr_ok  = (int'(cfg_out) < N_OUT) && (int'(cfg_term) < N_TERM);
  assign row_idx  = RW'(cfg_out) * RW'(N_TERM) + RW'(cfg_term);
  assign cfg_busy = cfg_erase;
  assign cfg_rdata = addr_ok ? fuse_q[row_idx] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) fuse_q[r] <= '0;
    end else if (cfg_erase) begin
      for (int r = 0; r < ROWS; r++) fuse_q[r] <= '0;
    end else if (cfg_wr && addr_ok) begin
      fuse_q[row_idx] <= cfg_wdata;
    end
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lit[2*i]   = in_data[i];
    assign lit[2*i+1] = ~in_data[i];
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_term
    assign term[r] = &(lit | fuse_q[r]);
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    assign out_n[o] = ~|term[o*N_TERM +: N_TERM];
  end
endmodule

// File: rtl/fuse_nor_array_chk.sv
module fuse_nor_array_chk #(
  parameter int N_IN   = 11,
  parameter int N_OUT  = 3,
  parameter int N_TERM = 4
) (
  input logic                                   clk,
  input logic                                   rst_n,
  input logic [N_OUT-1:0]                       out_n,
  input logic                                   cfg_erase,
  input logic                                   cfg_wr,
  input logic [(N_OUT>1?$clog2(N_OUT):1)-1:0]   cfg_out,
  input logic [(N_TERM>1?$clog2(N_TERM):1)-1:0] cfg_term,
  input logic [2*N_IN-1:0]                      cfg_wdata,
  input logic [2*N_IN-1:0]                      cfg_rdata,
  input logic                                   cfg_busy
);
  p_erase_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_erase |=> (cfg_rdata == '0));

  p_erased_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_erase |=> (&out_n));

  p_busy_drops_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_busy && cfg_wr) |=> (cfg_rdata == '0));

  p_write_readback_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_erase && int'(cfg_out) < N_OUT) |=>
      (!($stable(cfg_out) && $stable(cfg_term)) || cfg_rdata == $past(cfg_wdata)));

  p_bad_index_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cfg_out) >= N_OUT) |-> (cfg_rdata == '0));
endmodule

bind fuse_nor_array fuse_nor_array_chk #(.N_IN(N_IN), .N_OUT(N_OUT), .N_TERM(N_TERM)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_n(out_n), .cfg_erase(cfg_erase), .cfg_wr(cfg_wr),
  .cfg_out(cfg_out), .cfg_term(cfg_term), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .cfg_busy(cfg_busy)
);

// File: tb/fuse_nor_array_bench.sv
module fuse_nor_array_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [10:0] in_data = '0;
  logic [2:0]  out_n;
  logic        cfg_erase = 0, cfg_wr = 0;
  logic [1:0]  cfg_out = '0, cfg_term = '0;
  logic [21:0] cfg_wdata = '0;
  logic [21:0] cfg_rdata;
  logic        cfg_busy;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [21:0] m [12];

  fuse_nor_array u_fuse_nor_array (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .out_n(out_n),
    .cfg_erase(cfg_erase), .cfg_wr(cfg_wr), .cfg_out(cfg_out), .cfg_term(cfg_term),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_busy(cfg_busy));

  always #10 clk = ~clk;

  function automatic logic [2:0] exp_out(input logic [10:0] x);
    logic [2:0] e;
    for (int o = 0; o < 3; o++) begin
      logic any = 0;
      for (int t = 0; t < 4; t++) begin
        logic tv = 1;
        for (int i = 0; i < 11; i++) begin
          if (!m[o*4+t][2*i]   && !x[i]) tv = 0;
          if (!m[o*4+t][2*i+1] &&  x[i]) tv = 0;
        end
        any |= tv;
      end
      e[o] = ~any;
    end
    return e;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic wr(input int o, input int t, input logic [21:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_out = 2'(o); cfg_term = 2'(t); cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
    if (o < 3) m[o*4+t] = d;
    #1;
  endtask

  task automatic erase();
    @(negedge clk);
    cfg_erase = 1;
    @(negedge clk);
    cfg_erase = 0;
    for (int r = 0; r < 12; r++) m[r] = '0;
    #1;
  endtask

  task automatic readrow(input int o, input int t, input string req);
    cfg_out = 2'(o); cfg_term = 2'(t);
    #1;
    chk(req, 32'(cfg_rdata), (o < 3) ? 32'(m[o*4+t]) : 32'd0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int r = 0; r < 12; r++) m[r] = '0;
    #45 rst_n = 1;
    @(negedge clk); #1;
    // R1 reset state
    chk("R1 outputs", 32'(out_n), 32'h7);
    readrow(0, 0, "R1 readback");
    readrow(2, 3, "R1 readback");

    // R2/R3/R10: row(0,0) keeps only in0-true literal
    in_data = 11'h001; #1;
    wr(0, 0, ~22'h000001);
    chk("R2 true literal in0=1", 32'(out_n), 32'h6);
    in_data = 11'h000; #1;
    chk("R2 true literal in0=0", 32'(out_n), 32'h7);
    // R6 timing: old map visible before edge
    @(negedge clk);
    cfg_wr = 1; cfg_out = 2'd1; cfg_term = 2'd2; cfg_wdata = ~22'h000008;
    #1;
    chk("R6 before edge", 32'(out_n), 32'h7);
    @(negedge clk);
    cfg_wr = 0; m[6] = ~22'h000008; #1;
    chk("R6 after edge, in1 inverted literal", 32'(out_n), 32'h5);
    chk("R10 others untouched", 32'(out_n[2]), 32'h1);
    readrow(1, 2, "R6 readback");
    // R3 all blown
    wr(2, 3, '1);
    in_data = 11'h7FF; #1;
    chk("R3 all-blown term", 32'(out_n), 32'(exp_out(in_data)));
    chk("R3 out2 low", 32'(out_n[2]), 32'h0);

    // R7 erase
    erase();
    chk("R7 outputs high", 32'(out_n), 32'h7);
    readrow(0, 0, "R7 row0");
    readrow(1, 2, "R7 row6");
    readrow(2, 3, "R7 row11");

    // R8 erase with concurrent write
    wr(0, 1, '1);
    @(negedge clk);
    cfg_erase = 1; cfg_wr = 1; cfg_out = 2'd1; cfg_term = 2'd0; cfg_wdata = '1;
    #1;
    chk("R8 busy", 32'(cfg_busy), 32'h1);
    @(negedge clk);
    cfg_erase = 0; cfg_wr = 0;
    for (int r = 0; r < 12; r++) m[r] = '0;
    #1;
    readrow(1, 0, "R8 write dropped");
    readrow(0, 1, "R8 erase cleared");
    chk("R8 outputs high", 32'(out_n), 32'h7);

    // R9 out of range
    wr(3, 0, '1);
    chk("R9 outputs unchanged", 32'(out_n), 32'h7);
    readrow(3, 0, "R9 read zero");
    for (int r = 0; r < 12; r++) readrow(r / 4, r % 4, "R9 no row touched");

    // R5: a term with both literals of in5 intact never fires
    wr(1, 1, ~22'h000C00);
    in_data = 11'h020; #1;
    chk("R5 contradiction term", 32'(out_n), 32'h7);
    in_data = 11'h000; #1;
    chk("R5 contradiction term", 32'(out_n), 32'h7);

    // R4 random mix
    for (int k = 0; k < 400; k++) begin
      int sel = $urandom % 10;
      if (sel < 4) begin
        logic [21:0] d;
        for (int b = 0; b < 22; b++) d[b] = ($urandom % 7) != 0;
        wr($urandom % 3, $urandom % 4, d);
      end else if (sel == 4 && ($urandom % 8) == 0) begin
        erase();
      end else begin
        @(negedge clk);
        in_data = 11'($urandom);
        #1;
      end
      chk("R4 NOR of terms", 32'(out_n), 32'(exp_out(in_data)));
      if (k % 5 == 0) readrow($urandom % 3, $urandom % 4, "R6 random readback");
    end

    done = 1;
    finish_run();
  end
endmodule